// File: doc/BRIEF.md
# Shadow Return-Address Checker

This block sits beside a processor pipeline and keeps a private on-chip copy of every subroutine return address. Each call strobe pushes the address the processor will later return to. Each return strobe carries the target that the processor actually fetched from its memory stack. The block checks that target against its private copy. A return whose target cannot be vouched for raises a one-cycle security alarm. Trap software then decides whether the cause was a misprediction or an attack.

Ordinary code returns in strict last-in first-out order, and those returns complete in the same cycle. Some unwinds legitimately skip several frames, for example a long jump out of nested calls. To allow for these, the block searches deeper into its copy when the newest entry does not match. It probes one entry per cycle and raises a busy output that stalls the pipeline while the search runs. A hit deeper down discards every frame that was skipped. A miss everywhere leaves the copy untouched and raises the alarm. When the copy is full, a further call drops the oldest entry and sets a sticky overflow flag.

Top module: `sras_top`

## Requirements
- R1: After reset, `busy_o`, `alarm_o` and `overflow_o` are 0 and the private stack holds no entries.
- R2: A return whose address equals the newest stored entry removes that entry. In the cycle after the return, `busy_o` and `alarm_o` are both 0. Calls and returns are never asserted in the same cycle.
- R3: A return presented while the stack holds no entries raises `alarm_o` in the cycle after the return, and it never raises `busy_o`.
- R4: A return that misses the newest entry but matches the entry k positions below it (k ≥ 1) holds `busy_o` high for exactly k cycles after the return. It then removes that entry and every entry above it, and it raises no alarm.
- R5: A return that matches no stored entry holds `busy_o` high for (entries − 1) cycles. The alarm then follows as a single-cycle pulse. The stack contents are left unchanged, so the same entries are later returned in their original order.
- R6: A call when DEPTH entries are already stored discards the oldest entry, keeps the newest DEPTH entries and sets `overflow_o`.
- R7: `overflow_o` stays at 1 once set, until reset clears it.
- R8: Call and return strobes that arrive while `busy_o` is 1 are ignored and do not change the stack.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| call_i | input | 1 | A subroutine call retires this cycle |
| call_addr_i | input | ADDR_W | Return address that the call will later use |
| ret_i | input | 1 | A subroutine return retires this cycle |
| ret_addr_i | input | ADDR_W | Return target that the processor loaded from memory |
| busy_o | output | 1 | Deep search in progress; the pipeline must stall |
| alarm_o | output | 1 | One-cycle pulse: the return target is not trusted |
| overflow_o | output | 1 | Sticky: at least one oldest entry was discarded |

## Verification
The matching function is tried with several kinds of return. Plain nested returns show that the top-of-stack path needs no stall. Unwinds that skip two and four frames show that the search stops at the right depth and discards exactly the skipped frames. A target that is absent from a three-entry stack and from a one-entry stack shows that the search is exhaustive but not destructive, because the old entries are then returned normally. Returns on an empty stack, a ninth call into a depth-eight stack, and a call injected during a search show the alarm, the drop-oldest rule and the stall masking.

// File: rtl/sras_pkg.sv
package sras_pkg;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_SCAN = 1'b1
   } scan_state_e;

endpackage

// File: rtl/sras_ring.sv
module sras_ring #(
   parameter int ADDR_W = 32,
   parameter int DEPTH  = 16,
   localparam int PW    = $clog2(DEPTH),
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_i,
   input  logic [ADDR_W-1:0] push_data_i,
   input  logic              drop_i,
   input  logic [CW-1:0]     drop_cnt_i,
   input  logic [PW-1:0]     rd_depth_i,
   output logic [ADDR_W-1:0] top_data_o,
   output logic [ADDR_W-1:0] rd_data_o,
   output logic [CW-1:0]     count_o,
   output logic              ovf_o
);

   logic [ADDR_W-1:0] slot_q [DEPTH];
   logic [PW-1:0]     wr_ptr_q;
   logic [CW-1:0]     count_q;
   logic              ovf_q;
   logic              full;
   logic [PW-1:0]     top_idx;
   logic [PW-1:0]     rd_idx;
   logic [CW-1:0]     ptr_wide;

   assign full     = (count_q == CW'(DEPTH));
   assign top_idx  = wr_ptr_q - PW'(1);
   assign rd_idx   = top_idx - rd_depth_i;
   assign ptr_wide = CW'(wr_ptr_q) - drop_cnt_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr_q <= '0;
         count_q  <= '0;
         ovf_q    <= 1'b0;
      end else if (push_i) begin
         wr_ptr_q <= wr_ptr_q + PW'(1);
         if (full) ovf_q <= 1'b1;
         else      count_q <= count_q + CW'(1);
      end else if (drop_i) begin
         wr_ptr_q <= ptr_wide[PW-1:0];
         count_q  <= count_q - drop_cnt_i;
      end
   end

   always_ff @(posedge clk) begin
      if (push_i) slot_q[wr_ptr_q] <= push_data_i;
   end

   assign top_data_o = slot_q[top_idx];
   assign rd_data_o  = slot_q[rd_idx];
   assign count_o    = count_q;
   assign ovf_o      = ovf_q;

   // R6
   count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      count_q <= CW'(DEPTH));

   // R6
   full_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && full) |=> (ovf_q && count_q == CW'(DEPTH)));

endmodule

// File: rtl/sras_scan.sv
module sras_scan
   import sras_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DEPTH  = 16,
   localparam int PW    = $clog2(DEPTH),
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              call_i,
   input  logic              ret_i,
   input  logic [ADDR_W-1:0] ret_addr_i,
   input  logic [ADDR_W-1:0] top_data_i,
   input  logic [ADDR_W-1:0] rd_data_i,
   input  logic [CW-1:0]     count_i,
   output logic              push_o,
   output logic              drop_o,
   output logic [CW-1:0]     drop_cnt_o,
   output logic [PW-1:0]     rd_depth_o,
   output logic              busy_o,
   output logic              alarm_o
);

   scan_state_e       state_q, state_d;
   logic [PW-1:0]     idx_q, idx_d;
   logic [ADDR_W-1:0] tgt_q, tgt_d;
   logic              alarm_q, alarm_d;
   logic              idle;
   logic              deep_hit;
   logic              last_probe;

   assign idle       = (state_q == ST_IDLE);
   assign deep_hit   = (rd_data_i == tgt_q);
   assign last_probe = (CW'(idx_q) == count_i - CW'(1));

   always_comb begin
      state_d    = state_q;
      idx_d      = idx_q;
      tgt_d      = tgt_q;
      alarm_d    = 1'b0;
      push_o     = 1'b0;
      drop_o     = 1'b0;
      drop_cnt_o = '0;
      if (idle) begin
         push_o = call_i;
         if (ret_i) begin
            if (count_i == '0) begin
               alarm_d = 1'b1;
            end else if (top_data_i == ret_addr_i) begin
               drop_o     = 1'b1;
               drop_cnt_o = CW'(1);
            end else if (count_i == CW'(1)) begin
               alarm_d = 1'b1;
            end else begin
               state_d = ST_SCAN;
               idx_d   = PW'(1);
               tgt_d   = ret_addr_i;
            end
         end
      end else begin
         if (deep_hit) begin
            drop_o     = 1'b1;
            drop_cnt_o = CW'(idx_q) + CW'(1);
            state_d    = ST_IDLE;
         end else if (last_probe) begin
            alarm_d = 1'b1;
            state_d = ST_IDLE;
         end else begin
            idx_d = idx_q + PW'(1);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         idx_q   <= '0;
         tgt_q   <= '0;
         alarm_q <= 1'b0;
      end else begin
         state_q <= state_d;
         idx_q   <= idx_d;
         tgt_q   <= tgt_d;
         alarm_q <= alarm_d;
      end
   end

   assign rd_depth_o = idx_q;
   assign busy_o     = !idle;
   assign alarm_o    = alarm_q;

   // R4
   probe_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> (CW'(idx_q) < count_i && idx_q != '0));

   // R8
   busy_no_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> !push_o);

endmodule

// File: rtl/sras_top.sv
module sras_top #(
   parameter int ADDR_W = 32,
   parameter int DEPTH  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              call_i,
   input  logic [ADDR_W-1:0] call_addr_i,
   input  logic              ret_i,
   input  logic [ADDR_W-1:0] ret_addr_i,
   output logic              busy_o,
   output logic              alarm_o,
   output logic              overflow_o
);

   localparam int PW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("sras_top: DEPTH must be a power of two, at least 2");
      end
      if (ADDR_W < 1) begin : g_bad_width
         $error("sras_top: ADDR_W must be positive");
      end
   endgenerate

   logic              push;
   logic              drop;
   logic [CW-1:0]     drop_cnt;
   logic [PW-1:0]     rd_depth;
   logic [ADDR_W-1:0] top_data;
   logic [ADDR_W-1:0] rd_data;
   logic [CW-1:0]     count;

   sras_ring #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_ring (
      .clk         (clk),
      .rst_n       (rst_n),
      .push_i      (push),
      .push_data_i (call_addr_i),
      .drop_i      (drop),
      .drop_cnt_i  (drop_cnt),
      .rd_depth_i  (rd_depth),
      .top_data_o  (top_data),
      .rd_data_o   (rd_data),
      .count_o     (count),
      .ovf_o       (overflow_o)
   );

   sras_scan #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_scan (
      .clk        (clk),
      .rst_n      (rst_n),
      .call_i     (call_i),
      .ret_i      (ret_i),
      .ret_addr_i (ret_addr_i),
      .top_data_i (top_data),
      .rd_data_i  (rd_data),
      .count_i    (count),
      .push_o     (push),
      .drop_o     (drop),
      .drop_cnt_o (drop_cnt),
      .rd_depth_o (rd_depth),
      .busy_o     (busy_o),
      .alarm_o    (alarm_o)
   );

   // R2
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(call_i && ret_i));

   // R2
   top_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && ret_i && count != '0 && top_data == ret_addr_i)
      |=> (!busy_o && !alarm_o && count == $past(count) - CW'(1)));

   // R3
   empty_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && ret_i && count == '0) |=> (alarm_o && !busy_o));

   // R4
   scan_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && ret_i && count > CW'(1) && top_data != ret_addr_i)
      |=> busy_o);

   // R5
   alarm_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (alarm_o && !ret_i) |=> !alarm_o);

   // R5
   miss_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(alarm_o) |-> $stable(count));

   // R7
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      overflow_o |=> overflow_o);

endmodule

// File: tb/tb_sras_top.sv
module tb_sras_top;

   localparam int CLK_PERIOD = 10;
   localparam int AW         = 32;
   localparam int DEP        = 8;
   localparam int WATCHDOG   = 50000;

   typedef struct packed {
      logic          is_ret;
      logic [AW-1:0] addr;
      logic [3:0]    nbusy;
      logic          alarm;
   } vec_t;

   localparam int NV = 27;
   localparam vec_t VECS [NV] = '{
      '{1'b1, 32'h0000_00A0, 4'd0, 1'b1},  // R3 empty after reset
      '{1'b0, 32'h0000_0100, 4'd0, 1'b0},
      '{1'b0, 32'h0000_0200, 4'd0, 1'b0},
      '{1'b0, 32'h0000_0300, 4'd0, 1'b0},
      '{1'b1, 32'h0000_0300, 4'd0, 1'b0},  // R2
      '{1'b1, 32'h0000_0200, 4'd0, 1'b0},  // R2
      '{1'b0, 32'h0000_0210, 4'd0, 1'b0},
      '{1'b0, 32'h0000_0220, 4'd0, 1'b0},
      '{1'b0, 32'h0000_0230, 4'd0, 1'b0},
      '{1'b1, 32'h0000_0210, 4'd2, 1'b0},  // R4 skip two frames
      '{1'b1, 32'h0000_0999, 4'd0, 1'b1},  // R5 single entry miss
      '{1'b1, 32'h0000_0100, 4'd0, 1'b0},  // R5 entry kept
      '{1'b0, 32'h0000_0011, 4'd0, 1'b0},
      '{1'b0, 32'h0000_0022, 4'd0, 1'b0},
      '{1'b0, 32'h0000_0033, 4'd0, 1'b0},
      '{1'b1, 32'h0000_0077, 4'd2, 1'b1},  // R5 full search miss
      '{1'b1, 32'h0000_0033, 4'd0, 1'b0},  // R5 unchanged
      '{1'b1, 32'h0000_0022, 4'd0, 1'b0},
      '{1'b1, 32'h0000_0011, 4'd0, 1'b0},
      '{1'b1, 32'h0000_0011, 4'd0, 1'b1},  // R3
      '{1'b0, 32'h0000_0001, 4'd0, 1'b0},
      '{1'b0, 32'h0000_0002, 4'd0, 1'b0},
      '{1'b0, 32'h0000_0003, 4'd0, 1'b0},
      '{1'b0, 32'h0000_0004, 4'd0, 1'b0},
      '{1'b0, 32'h0000_0005, 4'd0, 1'b0},
      '{1'b1, 32'h0000_0001, 4'd4, 1'b0},  // R4 skip four frames
      '{1'b1, 32'h0000_0002, 4'd0, 1'b1}   // R4 all discarded
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          call_i = 1'b0;
   logic [AW-1:0] call_addr_i = '0;
   logic          ret_i = 1'b0;
   logic [AW-1:0] ret_addr_i = '0;
   logic          busy_o;
   logic          alarm_o;
   logic          overflow_o;

   int n_checks = 0;
   int n_fails  = 0;
   int cycles   = 0;
   bit finished = 1'b0;

   sras_top #(.ADDR_W(AW), .DEPTH(DEP)) dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .call_i      (call_i),
      .call_addr_i (call_addr_i),
      .ret_i       (ret_i),
      .ret_addr_i  (ret_addr_i),
      .busy_o      (busy_o),
      .alarm_o     (alarm_o),
      .overflow_o  (overflow_o)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   task automatic check(input string tag, input string what,
                        input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fails++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic do_call(input logic [AW-1:0] a);
      @(negedge clk);
      call_i = 1'b1;
      call_addr_i = a;
      @(negedge clk);
      call_i = 1'b0;
   endtask

   task automatic do_ret(input logic [AW-1:0] a, input int exp_busy,
                         input int exp_alarm, input string tag);
      int nb;
      @(negedge clk);
      ret_i = 1'b1;
      ret_addr_i = a;
      @(negedge clk);
      ret_i = 1'b0;
      nb = 0;
      while (busy_o && nb < 64) begin
         nb++;
         @(negedge clk);
      end
      check(tag, "busy cycles", nb, exp_busy);
      check(tag, "alarm", int'(alarm_o), exp_alarm);
      if (exp_alarm != 0) begin
         @(negedge clk);
         check(tag, "alarm pulse width", int'(alarm_o), 0);
      end
   endtask

   task automatic apply_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
         $finish;
      end
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > WATCHDOG) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual %0d expected below %0d cycles",
                     cycles, WATCHDOG);
            finish_run();
         end
      end
   end

   initial begin
      apply_reset();
      // R1 reset state
      check("R1", "busy", int'(busy_o), 0);
      check("R1", "alarm", int'(alarm_o), 0);
      check("R1", "overflow", int'(overflow_o), 0);

      for (int i = 0; i < NV; i++) begin
         if (VECS[i].is_ret) begin
            string tag;
            if (VECS[i].alarm) tag = (VECS[i].nbusy == 0) ? "R3/R5" : "R5";
            else               tag = (VECS[i].nbusy == 0) ? "R2" : "R4";
            do_ret(VECS[i].addr, int'(VECS[i].nbusy), int'(VECS[i].alarm), tag);
         end else begin
            do_call(VECS[i].addr);
         end
      end

      // R8: call injected while a search is running is dropped
      do_call(32'h50);
      do_call(32'h60);
      do_call(32'h70);
      @(negedge clk);
      ret_i = 1'b1;
      ret_addr_i = 32'h50;
      @(negedge clk);
      ret_i = 1'b0;
      check("R8", "busy during search", int'(busy_o), 1);
      call_i = 1'b1;
      call_addr_i = 32'hBAD;
      @(negedge clk);
      call_i = 1'b0;
      check("R8", "busy second cycle", int'(busy_o), 1);
      @(negedge clk);
      check("R8", "search done", int'(busy_o), 0);
      do_ret(32'hBAD, 0, 1, "R8");

      // R6: ninth call into a depth-eight stack drops the oldest
      for (int i = 0; i < DEP; i++) do_call(32'h1000 + i);
      check("R6", "overflow while exactly full", int'(overflow_o), 0);
      do_call(32'h1000 + DEP);
      check("R6", "overflow after extra call", int'(overflow_o), 1);
      for (int i = DEP; i >= 1; i--) do_ret(32'h1000 + i, 0, 0, "R6");
      do_ret(32'h1000, 0, 1, "R6");
      // R7 sticky flag
      check("R7", "overflow still set", int'(overflow_o), 1);
      apply_reset();
      check("R7", "overflow cleared by reset", int'(overflow_o), 0);
      do_ret(32'h1234, 0, 1, "R1");

      finish_run();
   end

endmodule